// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller with Atomic Output Update

This block controls one sixteen-pin general-purpose I/O port from a simple 32-bit register bus. Software sets each pin's direction and output level, reads the pin levels back through a clock-domain synchronizer, and can raise or lower any group of output bits with one write. No read-modify-write sequence is needed for that, so two agents that share the port cannot overwrite each other's changes.

Each pin also has a pull-up enable and an open-drain enable. Both are protected. A protection register starts out locked at reset. Software must clear its lock bit in one write and then set its configuration-enable bit in a later write. Only after that are writes to the pull-up and open-drain word accepted. The pad side receives a drive value, an output enable and a pull-up enable for every pin.

Register map (word offsets): 0x00 control, 0x04 input, 0x08 set/clear, 0x0C pin configuration, 0x10 protection. Address bits [1:0] are ignored. The byte strobe `bus_be[k]` enables write data bits [8k+7:8k].

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, direction is all input (0), output data is 0, pull-up and open-drain are all off, and the protection word reads 0x00000080 (lock bit 7 set, configuration-enable bit 6 clear). As a result `pad_oe` and `pad_pu` are 0.
- R2: The control word at 0x00 is read/write. Bits [15:0] hold direction (1 = output) and bits [31:16] hold output data. Only the bytes whose strobe is 1 are written.
- R3: The input word at 0x04 returns in bits [15:0] the `pad_in` levels after exactly two clock edges of synchronization. Bits [31:16] read 0. This holds for pins set as outputs too.
- R4: The set/clear word at 0x08 always reads 0. Writing 1 to bit k of [15:0] sets output bit k. Writing 1 to bit k+16 clears output bit k. Bits written as 0 leave their output bit unchanged, and direction is never altered by this word.
- R5: If one set/clear write has both the set bit and the clear bit for the same pin, that output bit becomes 0.
- R6: `pad_pu[k]` is 1 only when the pull-up enable for pin k is 1 and pin k is an input.
- R7: With open-drain off, an output pin has `pad_oe` = 1 and drives its output data bit. With open-drain on, an output pin drives 0 when its data bit is 0, and releases the pad (`pad_oe` = 0) when its data bit is 1.
- R8: The configuration word at 0x0C (bits [15:0] pull-up enable, bits [31:16] open-drain enable) changes only on a write made while the configuration-enable bit is 1.
- R9: A write to the protection word (at 0x10, byte 0 strobe) loads the lock bit 7 from the write data. It loads the configuration-enable bit 6 only if the lock bit was already 0 before that write.
- R10: Input pins have `pad_oe` = 0.
- R11: An address outside the five words reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Raw pad levels |
| pad_out | output | 16 | Value driven on each pad |
| pad_oe | output | 16 | Pad output enable |
| pad_pu | output | 16 | Pad pull-up enable |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a set and a clear aimed at the same pin within one set/clear write. The bench sends a word that also holds an unrelated set bit, then checks that the shared pins read 0 and the other pin reads 1. The second pair is clearing the lock and setting the configuration-enable bit in a single protection write. The bench sends that write from the locked state and expects the enable to remain 0, and it expects a later configuration write to be ignored until the enable is set in a separate write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 16;
    localparam int BUS_W  = 32;
    localparam int BE_W   = BUS_W / 8;

    // Protection word bit positions.
    localparam int LOCK_BIT = 7;
    localparam int CEN_BIT  = 6;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_IN,
        SEL_SC,
        SEL_CFG,
        SEL_WP,
        SEL_NONE
    } reg_sel_e;

    // Layout of the control word: upper half output data, lower half direction.
    typedef struct packed {
        logic [PORT_W-1:0] odata;
        logic [PORT_W-1:0] dir;
    } port_ctrl_t;

    // Layout of the configuration word: upper half open-drain, lower half pull-up.
    typedef struct packed {
        logic [PORT_W-1:0] od;
        logic [PORT_W-1:0] pu;
    } pin_cfg_t;

    function automatic reg_sel_e decode_word(input int unsigned idx);
        case (idx)
            0:       return SEL_CTRL;
            1:       return SEL_IN;
            2:       return SEL_SC;
            3:       return SEL_CFG;
            4:       return SEL_WP;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] strobe_mask(input logic [BE_W-1:0] be);
        logic [BUS_W-1:0] m;
        for (int b = 0; b < BE_W; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] merge_bytes(input logic [BUS_W-1:0] old_v,
                                                     input logic [BUS_W-1:0] new_v,
                                                     input logic [BE_W-1:0]  be);
        logic [BUS_W-1:0] m;
        m = strobe_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction

    // Clear dominates set on the same bit.
    function automatic logic [PORT_W-1:0] set_clear(input logic [PORT_W-1:0] cur,
                                                    input logic [PORT_W-1:0] set_m,
                                                    input logic [PORT_W-1:0] clr_m);
        return (cur | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_wprot.sv
module gpio_wprot
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wbyte,
    output logic       lock,
    output logic       cfg_en
);

    logic lock_q;
    logic cen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
            cen_q  <= 1'b0;
        end else if (wr) begin
            lock_q <= wbyte[LOCK_BIT];
            if (!lock_q) begin
                cen_q <= wbyte[CEN_BIT];
            end
        end
    end

    assign lock   = lock_q;
    assign cfg_en = cen_q;

    AST_EN_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(cen_q)); // R9

endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
    parameter int W = 16
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] odata,
    input  logic [W-1:0] od,
    input  logic [W-1:0] pu,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_pin
            always_comb begin
                if (dir[k]) begin
                    pad_pu[k] = 1'b0;
                    if (od[k]) begin
                        pad_out[k] = 1'b0;
                        pad_oe[k]  = ~odata[k];
                    end else begin
                        pad_out[k] = odata[k];
                        pad_oe[k]  = 1'b1;
                    end
                end else begin
                    pad_pu[k]  = pu[k];
                    pad_out[k] = 1'b0;
                    pad_oe[k]  = 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       pad_in,
    output logic [15:0]       pad_out,
    output logic [15:0]       pad_oe,
    output logic [15:0]       pad_pu
);

    localparam int WORD_W = ADDR_W - 2;

    reg_sel_e          sel;
    port_ctrl_t        ctrl_q;
    pin_cfg_t          cfg_q;
    logic [PORT_W-1:0] pin_lvl;
    logic              lock;
    logic              cfg_en;
    logic              wr_ctrl, wr_sc, wr_cfg, wr_wp;
    logic [BUS_W-1:0]  sc_word;
    logic [PORT_W-1:0] sc_set, sc_clr;

    assign sel     = decode_word(int'(bus_addr[ADDR_W-1:2]));
    assign wr_ctrl = bus_we && (sel == SEL_CTRL);
    assign wr_sc   = bus_we && (sel == SEL_SC);
    assign wr_cfg  = bus_we && (sel == SEL_CFG) && cfg_en;
    assign wr_wp   = bus_we && (sel == SEL_WP) && bus_be[0];

    assign sc_word = bus_wdata & strobe_mask(bus_be);
    assign sc_set  = sc_word[PORT_W-1:0];
    assign sc_clr  = sc_word[BUS_W-1:PORT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= port_ctrl_t'(merge_bytes(ctrl_q, bus_wdata, bus_be));
        end else if (wr_sc) begin
            ctrl_q.odata <= set_clear(ctrl_q.odata, sc_set, sc_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= pin_cfg_t'(merge_bytes(cfg_q, bus_wdata, bus_be));
        end
    end

    gpio_wprot u_wprot (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_wp),
        .wbyte  (bus_wdata[7:0]),
        .lock   (lock),
        .cfg_en (cfg_en)
    );

    gpio_in_sync #(
        .W      (PORT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_lvl)
    );

    gpio_pad_drv #(
        .W (PORT_W)
    ) u_pad (
        .dir     (ctrl_q.dir),
        .odata   (ctrl_q.odata),
        .od      (cfg_q.od),
        .pu      (cfg_q.pu),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_IN:   bus_rdata = {{(BUS_W-PORT_W){1'b0}}, pin_lvl};
            SEL_CFG:  bus_rdata = cfg_q;
            SEL_WP: begin
                bus_rdata[LOCK_BIT] = lock;
                bus_rdata[CEN_BIT]  = cfg_en;
            end
            default:  bus_rdata = '0;
        endcase
    end

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_sc |=> ((ctrl_q.odata & $past(sc_clr)) == '0)); // R5

    AST_SC_KEEPS_DIR: assert property (@(posedge clk) disable iff (rst)
        wr_sc |=> $stable(ctrl_q.dir)); // R4

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q)); // R8

    AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & ctrl_q.dir) == '0); // R6

    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & cfg_q.od & ctrl_q.odata) == '0); // R7

    AST_IN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_IN) |-> (bus_rdata[31:16] == '0)); // R3

    AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~ctrl_q.dir) == '0); // R10

endmodule

// File: tb/gpio_port_ctl_bench.sv
module gpio_port_ctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pu;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_port_ctl u_gpio_port_ctl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu)
    );

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_IN   = 5'h04;
    localparam logic [4:0] A_SC   = 5'h08;
    localparam logic [4:0] A_CFG  = 5'h0C;
    localparam logic [4:0] A_WP   = 5'h10;
    localparam logic [4:0] A_GAP  = 5'h14;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_be    = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_CFG, v);  check("R1 cfg", v, 32'h0);
        rd(A_WP, v);   check("R1 protect", v, 32'h80);
        check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1 pad_pu", {16'h0, pad_pu}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(A_CTRL, 32'h1234_00FF, 4'hF);
        rd(A_CTRL, v); check("R2 full write", v, 32'h1234_00FF);
        check("R7 push-pull oe", {16'h0, pad_oe}, 32'h0000_00FF);
        check("R10 inputs undriven", {16'h0, pad_oe & 16'hFF00}, 32'h0);
        check("R7 push-pull out", {16'h0, pad_out & pad_oe}, 32'h0000_0034);
        wr(A_CTRL, 32'hFFFF_FFFF, 4'b0010);
        rd(A_CTRL, v); check("R2 byte strobe", v, 32'h1234_FFFF);
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 16'hA5C3;
        @(negedge clk);
        rd(A_IN, v); check("R3 one edge", v, 32'h0);
        @(negedge clk);
        rd(A_IN, v); check("R3 two edges", v, 32'h0000_A5C3);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        wr(A_CTRL, 32'h0F0F_FFFF, 4'hF);
        wr(A_SC, 32'h0000_00F0, 4'hF);
        rd(A_CTRL, v); check("R4 set", v, 32'h0FFF_FFFF);
        wr(A_SC, 32'h000F_0000, 4'hF);
        rd(A_CTRL, v); check("R4 clear", v, 32'h0FF0_FFFF);
        rd(A_SC, v);   check("R4 reads zero", v, 32'h0);
        wr(A_SC, 32'h8001_8003, 4'hF);
        rd(A_CTRL, v); check("R5 clear wins", v, 32'h0FF2_FFFF);
    endtask

    task automatic t_protect();
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF, 4'hF);
        rd(A_CFG, v); check("R8 locked write", v, 32'h0);
        wr(A_WP, 32'h0000_0040, 4'h1);
        rd(A_WP, v);  check("R9 same-write enable", v, 32'h0);
        wr(A_CFG, 32'hFFFF_FFFF, 4'hF);
        rd(A_CFG, v); check("R8 still blocked", v, 32'h0);
        wr(A_WP, 32'h0000_0040, 4'h1);
        rd(A_WP, v);  check("R9 enabled", v, 32'h40);
        wr(A_CFG, 32'hFF00_00FF, 4'hF);
        rd(A_CFG, v); check("R8 accepted", v, 32'hFF00_00FF);
    endtask

    task automatic t_pads();
        wr(A_CTRL, 32'hFFFF_F0F0, 4'hF);
        check("R6 pull-up inputs", {16'h0, pad_pu}, 32'h0000_000F);
        check("R7 od release", {16'h0, pad_oe}, 32'h0000_00F0);
        check("R7 pp high", {16'h0, pad_out & pad_oe}, 32'h0000_00F0);
        wr(A_CTRL, 32'h0000_F0F0, 4'hF);
        check("R7 od drive low oe", {16'h0, pad_oe}, 32'h0000_F0F0);
        check("R7 od drive low out", {16'h0, pad_out}, 32'h0);
    endtask

    task automatic t_relock_gap();
        logic [31:0] v;
        wr(A_WP, 32'h0000_0080, 4'h1);
        rd(A_WP, v);   check("R9 relock", v, 32'h80);
        wr(A_CFG, 32'h0, 4'hF);
        rd(A_CFG, v);  check("R8 after relock", v, 32'hFF00_00FF);
        wr(A_GAP, 32'hFFFF_FFFF, 4'hF);
        rd(A_GAP, v);  check("R11 gap reads zero", v, 32'h0);
        rd(A_CTRL, v); check("R11 ctrl untouched", v, 32'h0000_F0F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_input();
        t_setclr();
        t_protect();
        t_pads();
        t_relock_gap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule